// File: doc/BRIEF.md
# Multiprocessor Miscellaneous Control Register

This block holds one 64-bit control and status word for a system controller that serves up to four processors. Software reaches it over a 32-bit CSR port, so every access is split into a low half and a high half. A low-half write only stages its data. The following high-half write commits the whole 64-bit value. A low-half read returns live data and captures the upper word. The next high-half read returns that captured upper word.

The fields follow different write rules. Per-CPU timer flags and inter-processor interrupt flags are cleared by writing ones. A request field sends an inter-processor interrupt to any CPU. Two arbitration capture fields are cleared together by one control bit. One of them only accepts new ones while it is empty. A small read/write field is kept as written. A neighbouring interval block pulses per-CPU timer set inputs. The flag bits drive the interrupt outputs directly. Every read merges the requesting CPU's index into bits 1:0.

Top module: `misc_ctrl_csr`

## Requirements
- R1: After reset every stored bit is zero and `ipi_o` and `timer_irq_o` are low. A read then returns only the requester index in bits 1:0, and zero in the upper word.
- R2: A write with `csr_hi_i`=0 only stages `csr_wdata_i` and changes nothing visible. A write with `csr_hi_i`=1 commits {`csr_wdata_i`, staged word} as the 64-bit write value in that cycle.
- R3: A read with `csr_hi_i`=0 returns bits 31:0 of the register ORed with `csr_cpu_i` in bits 1:0, in the same cycle, and captures bits 63:32. A read with `csr_hi_i`=1 returns the captured word, even if a commit has happened since the capture.
- R4: Bits 7:4 are the timer flags for CPUs 0..3. A committed one in bit 4+n clears that flag. `timer_irq_o[n]` equals bit 4+n.
- R5: Bits 11:8 are the inter-processor flags for CPUs 0..3. A committed one in bit 8+n clears that flag. A committed one in bit 12+n sets flag 8+n, and the set wins over a clear in the same write. `ipi_o[n]` equals bit 8+n.
- R6: A one-cycle pulse on `timer_set_i[n]` sets bit 4+n. If a commit clears that same bit in the same cycle, the bit ends up set.
- R7: A commit with bit 20 set clears bits 23:16, whatever else it carries.
- R8: A commit with bit 20 clear ORs its bits 23:20 into the register.
- R9: A commit with bit 20 clear loads its bits 19:16 into bits 19:16 only when that field is currently all zero. Otherwise the field is unchanged.
- R10: Bits 43:40 take the committed value. All other bits outside the fields above always read zero. This includes bit 28, which has no source that could set it.
- R11: No write ever sets a timer flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| csr_wr_i | input | 1 | write strobe |
| csr_rd_i | input | 1 | read strobe |
| csr_hi_i | input | 1 | half select: 0 for bits 31:0, 1 for bits 63:32 |
| csr_wdata_i | input | 32 | write data for the selected half |
| csr_cpu_i | input | 2 | index of the requesting CPU |
| timer_set_i | input | 4 | per-CPU timer flag set pulse |
| csr_rdata_o | output | 32 | read data for the selected half |
| ipi_o | output | 4 | per-CPU inter-processor interrupt |
| timer_irq_o | output | 4 | per-CPU interval timer interrupt |

## Verification
Two events can land on the same timer bit in one clock: a set pulse from the interval block and a committed write-one-to-clear. The bench drives `timer_set_i` during the same cycle as the high-half commit that clears that bit, and then checks that `timer_irq_o` stays high. A second collision can happen inside one write value. When bit 20 is set together with capture bits, the clear must win. When bit 20 is clear and the request field is not empty, the request field must stay unchanged. The bench checks both by reading the register back after each write.

// File: rtl/misc_csr_pkg.sv
package misc_csr_pkg;
  localparam int unsigned NCPU     = 4;
  localparam int unsigned HALF_W   = 32;
  localparam int unsigned FULL_W   = 2 * HALF_W;
  localparam int unsigned CPU_W    = 2;
  localparam int unsigned TMR_LSB  = 4;
  localparam int unsigned IPI_LSB  = 8;
  localparam int unsigned IREQ_LSB = 12;
  localparam int unsigned ABW_LSB  = 16;
  localparam int unsigned ABT_LSB  = 20;
  localparam int unsigned ACL_BIT  = 20;
  localparam int unsigned RW_LSB   = 40;
  localparam int unsigned RW_W     = 4;
endpackage

// File: rtl/misc_csr_bridge.sv
module misc_csr_bridge
  import misc_csr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic              hi_i,
  input  logic [HALF_W-1:0] wdata_i,
  input  logic [FULL_W-1:0] rd_full_i,
  output logic              commit_o,
  output logic [FULL_W-1:0] cval_o,
  output logic [HALF_W-1:0] rdata_o
);
  logic [HALF_W-1:0] stage_q, hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
      hold_q  <= '0;
    end else begin
      if (wr_i && !hi_i) stage_q <= wdata_i;
      if (rd_i && !hi_i) hold_q  <= rd_full_i[FULL_W-1:HALF_W];
    end
  end

  assign commit_o = wr_i & hi_i;
  assign cval_o   = {wdata_i, stage_q};
  assign rdata_o  = hi_i ? hold_q : rd_full_i[HALF_W-1:0];

  AST_STAGE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && hi_i) |=> $stable(stage_q)); // R2
  AST_HOLD_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_i && !hi_i) |=> $stable(hold_q)); // R3
endmodule

// File: rtl/misc_csr_fields.sv
module misc_csr_fields
  import misc_csr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_i,
  input  logic [FULL_W-1:0] val_i,
  input  logic [NCPU-1:0]   tset_i,
  output logic [FULL_W-1:0] reg_o
);
  logic [NCPU-1:0] tmr_q, ipi_q, abw_q, abt_q;
  logic [RW_W-1:0] rw_q;
  logic [NCPU-1:0] tmr_d, ipi_d, abw_d, abt_d;
  logic [RW_W-1:0] rw_d;
  logic            acl;

  assign acl = val_i[ACL_BIT];

  always_comb begin
    tmr_d = tmr_q | tset_i;
    ipi_d = ipi_q;
    abw_d = abw_q;
    abt_d = abt_q;
    rw_d  = rw_q;
    if (commit_i) begin
      // set pulse wins over clear on the same bit
      tmr_d = (tmr_q & ~val_i[TMR_LSB +: NCPU]) | tset_i;
      ipi_d = (ipi_q & ~val_i[IPI_LSB +: NCPU]) | val_i[IREQ_LSB +: NCPU];
      rw_d  = val_i[RW_LSB +: RW_W];
      if (acl) begin
        abw_d = '0;
        abt_d = '0;
      end else begin
        abt_d = abt_q | val_i[ABT_LSB +: NCPU];
        if (abw_q == '0) abw_d = val_i[ABW_LSB +: NCPU];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q <= '0;
      ipi_q <= '0;
      abw_q <= '0;
      abt_q <= '0;
      rw_q  <= '0;
    end else begin
      tmr_q <= tmr_d;
      ipi_q <= ipi_d;
      abw_q <= abw_d;
      abt_q <= abt_d;
      rw_q  <= rw_d;
    end
  end

  always_comb begin
    reg_o = '0;
    reg_o[TMR_LSB +: NCPU] = tmr_q;
    reg_o[IPI_LSB +: NCPU] = ipi_q;
    reg_o[ABW_LSB +: NCPU] = abw_q;
    reg_o[ABT_LSB +: NCPU] = abt_q;
    reg_o[RW_LSB +: RW_W]  = rw_q;
  end

  AST_TSET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tset_i != '0) |=> ((tmr_q & $past(tset_i)) == $past(tset_i))); // R6
  AST_NO_WRITE_TSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tset_i == '0) |=> ((tmr_q & ~$past(tmr_q)) == '0)); // R11
  AST_IPI_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |=> ((ipi_q & $past(val_i[IREQ_LSB +: NCPU])) == $past(val_i[IREQ_LSB +: NCPU]))); // R5
  AST_ACL_WIPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && acl) |=> (abw_q == '0 && abt_q == '0)); // R7
  AST_ABW_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && !acl && abw_q != '0) |=> $stable(abw_q)); // R9
  AST_ABT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(commit_i && acl) |=> ((abt_q & $past(abt_q)) == $past(abt_q))); // R8
endmodule

// File: rtl/misc_ctrl_csr.sv
module misc_ctrl_csr
  import misc_csr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              csr_wr_i,
  input  logic              csr_rd_i,
  input  logic              csr_hi_i,
  input  logic [HALF_W-1:0] csr_wdata_i,
  input  logic [CPU_W-1:0]  csr_cpu_i,
  input  logic [NCPU-1:0]   timer_set_i,
  output logic [HALF_W-1:0] csr_rdata_o,
  output logic [NCPU-1:0]   ipi_o,
  output logic [NCPU-1:0]   timer_irq_o
);
  logic              commit;
  logic [FULL_W-1:0] cval, reg_q, rd_full;

  assign rd_full = reg_q | FULL_W'(csr_cpu_i);

  misc_csr_bridge u_bridge (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (csr_wr_i),
    .rd_i      (csr_rd_i),
    .hi_i      (csr_hi_i),
    .wdata_i   (csr_wdata_i),
    .rd_full_i (rd_full),
    .commit_o  (commit),
    .cval_o    (cval),
    .rdata_o   (csr_rdata_o)
  );

  misc_csr_fields u_fields (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .commit_i (commit),
    .val_i    (cval),
    .tset_i   (timer_set_i),
    .reg_o    (reg_q)
  );

  assign ipi_o       = reg_q[IPI_LSB +: NCPU];
  assign timer_irq_o = reg_q[TMR_LSB +: NCPU];

  AST_TIMER_ONLY_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timer_set_i == '0) |=> ((timer_irq_o & ~$past(timer_irq_o)) == '0)); // R4
  AST_IPI_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit |=> $stable(ipi_o)); // R5
endmodule

// File: tb/misc_ctrl_csr_tb_top.sv
`timescale 1ns/1ps
module misc_ctrl_csr_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0, rd = 1'b0, hi = 1'b0;
  logic [31:0] wdata = '0;
  logic [1:0]  cpu = '0;
  logic [3:0]  tset = '0;
  logic [31:0] rdata;
  logic [3:0]  ipi, tirq;
  int          total = 0, bad = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  misc_ctrl_csr dut_i (
    .clk_i(clk), .rst_ni(rst_n), .csr_wr_i(wr), .csr_rd_i(rd), .csr_hi_i(hi),
    .csr_wdata_i(wdata), .csr_cpu_i(cpu), .timer_set_i(tset),
    .csr_rdata_o(rdata), .ipi_o(ipi), .timer_irq_o(tirq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr64(input logic [31:0] lo, input logic [31:0] up, input logic [3:0] ts = 4'd0);
    @(negedge clk); wr = 1; hi = 0; wdata = lo;
    @(negedge clk); hi = 1; wdata = up; tset = ts;
    @(negedge clk); wr = 0; hi = 0; tset = 0;
  endtask

  task automatic rd64(input logic [1:0] c, output logic [31:0] lo, output logic [31:0] up);
    @(negedge clk); rd = 1; hi = 0; cpu = c; #1 lo = rdata;
    @(negedge clk); hi = 1; #1 up = rdata;
    @(negedge clk); rd = 0; hi = 0;
  endtask

  task automatic t_reset();
    logic [31:0] lo, up;
    chk("R1 ipi", {28'd0, ipi}, 32'd0);
    chk("R1 timer", {28'd0, tirq}, 32'd0);
    rd64(2'd2, lo, up);
    chk("R1 low", lo, 32'h2);
    chk("R1 high", up, 32'h0);
  endtask

  task automatic t_split();
    @(negedge clk); wr = 1; hi = 0; wdata = 32'h0000_1000;
    @(negedge clk); wr = 0;
    @(negedge clk);
    chk("R2 staged only", {28'd0, ipi}, 32'd0);
    @(negedge clk); wr = 1; hi = 1; wdata = 32'h0;
    @(negedge clk); wr = 0; hi = 0;
    chk("R2 commit", {28'd0, ipi}, 32'h1);
    wr64(32'h0000_0100, 32'h0);
    chk("R5 ipi clear", {28'd0, ipi}, 32'h0);
  endtask

  task automatic t_ipi();
    logic [31:0] lo, up;
    wr64(32'h0000_A000, 32'h0);
    chk("R5 ipi set", {28'd0, ipi}, 32'hA);
    rd64(2'd1, lo, up);
    chk("R3 low merge", lo, 32'h0000_0A01);
    wr64(32'h0000_0A00 | 32'h0000_1000, 32'h0);
    chk("R5 req beats clear", {28'd0, ipi}, 32'h1);
    wr64(32'h0000_0F00, 32'h0);
    chk("R5 all clear", {28'd0, ipi}, 32'h0);
  endtask

  task automatic t_timer();
    @(negedge clk); tset = 4'b0011;
    @(negedge clk); tset = 4'b0000;
    chk("R6 pulse set", {28'd0, tirq}, 32'h3);
    wr64(32'h0000_0010, 32'h0);
    chk("R4 w1c", {28'd0, tirq}, 32'h2);
    wr64(32'h0000_0020, 32'h0, 4'b0010);
    chk("R6 set wins", {28'd0, tirq}, 32'h2);
    wr64(32'h0000_0020, 32'h0);
    chk("R4 cleared", {28'd0, tirq}, 32'h0);
    wr64(32'h0000_F000 & 32'h0, 32'h0);
    wr64(32'h0000_00F0, 32'h0);
    chk("R11 write no set", {28'd0, tirq}, 32'h0);
  endtask

  task automatic t_capture();
    logic [31:0] lo, up;
    wr64(32'h0023_0000, 32'h0);
    rd64(2'd0, lo, up);
    chk("R9 load empty", lo, 32'h0023_0000);
    wr64(32'h0041_0000, 32'h0);
    rd64(2'd0, lo, up);
    chk("R8 R9 or and lock", lo, 32'h0063_0000);
    wr64(32'h001F_0000, 32'h0);
    rd64(2'd0, lo, up);
    chk("R7 clear", lo, 32'h0);
    wr64(32'h0004_0000, 32'h0);
    rd64(2'd0, lo, up);
    chk("R9 reload", lo, 32'h0004_0000);
    wr64(32'h0010_0000, 32'h0);
    rd64(2'd0, lo, up);
    chk("R7 clear bit only", lo, 32'h0);
  endtask

  task automatic t_rw();
    logic [31:0] lo, up;
    wr64(32'h0, 32'h0000_0F00);
    rd64(2'd3, lo, up);
    chk("R10 rw low", lo, 32'h3);
    chk("R10 rw high", up, 32'h0000_0F00);
    // R3: capture survives a later commit
    @(negedge clk); rd = 1; hi = 0; cpu = 0;
    @(negedge clk); rd = 0;
    wr64(32'h0, 32'h0000_0500);
    @(negedge clk); rd = 1; hi = 1; #1 up = rdata;
    @(negedge clk); rd = 0; hi = 0;
    chk("R3 held high", up, 32'h0000_0F00);
    rd64(2'd0, lo, up);
    chk("R10 rw rewrite", up, 32'h0000_0500);
    wr64(32'h1F00_000F, 32'hFFFF_F0FF);
    rd64(2'd0, lo, up);
    chk("R10 unused low", lo, 32'h0);
    chk("R10 unused high", up, 32'h0);
  endtask

  initial begin
    #100000000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_split();
    t_ipi();
    t_timer();
    t_capture();
    t_rw();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule